// File: doc/BRIEF.md
# Dual-Width Serial Flash Command Front End

This block is the device side of a serial flash interface. A host frames each transaction by pulling the active-low select low. It then clocks an 8-bit opcode, an optional address and optional data through the block on SCK. The block turns that stream into simple parallel events for a memory back end: a command strobe with opcode and address, one strobe per written byte, and a request for each byte to be read. It serialises the returned bytes onto the data lines and drives the per-line output enables. The memory array, its timing and the pad drivers are outside the block.

After reset the block speaks a restricted single-bit protocol. Input arrives on line 0, output leaves on line 1, and only the read-type commands and the quad-enable command are honoured. A quad-enable opcode moves it to a 4-bit protocol on all four lines, where every opcode is accepted. A quad-reset opcode moves it back. SCK, select and the input lines are sampled by the system clock `clk`. Each SCK level must last at least two `clk` periods. SCK may idle low or high between transactions.

Top module: `sqf_front`

## Requirements
- R1: After reset the block is in single-bit mode. Opcode 0x03 sent MSB first on sio_in[0], followed by three address bytes (MSB first), gives one cmd_valid pulse carrying the opcode and the 24-bit address. The read bytes then appear MSB first on sio_out[1], with sio_oe equal to 4'b0010 throughout the data phase.
- R2: In single-bit mode only 0x03, 0x0B, 0x9F and 0x38 are acted on. Any other opcode, and every byte after it, produces no cmd_valid, no wr_valid and no output enable until select rises.
- R3: Opcode 0x38 switches the block to 4-bit mode from the next transaction on. In that mode each byte takes two SCK cycles, high nibble first on sio_in[3:0] and sio_out[3:0], and sio_oe is 4'b1111 during data out.
- R4: The outcome of a transaction does not depend on whether SCK idles low or high while select is high.
- R5: Raising select before the last address unit has been clocked aborts the command with no cmd_valid. The next transaction decodes a fresh opcode.
- R6: Opcode 0x0B inserts one dummy byte between address and data: eight SCK cycles in single-bit mode, two in 4-bit mode. The output enables stay off during it.
- R7: Opcode 0x9F gives cmd_valid with address 0 right after the opcode, and data out follows without an address.
- R8: In 4-bit mode any opcode other than 0x03, 0x0B, 0x9F, 0x38 and 0xFF takes three address bytes, then gives a cmd_valid pulse. After that, each further byte gives one wr_valid pulse with the byte on wr_data.
- R9: Opcode 0xFF in 4-bit mode returns the block to single-bit mode. In single-bit mode it has no effect.
- R10: sio_oe is non-zero only in a data-out phase. It is zero in the clk cycle after select is sampled high.
- R11: rd_req is a one-cycle pulse, issued once when data out begins and once after the last unit of each output byte. rd_data must be valid from the following clk cycle until the next SCK falling edge. A read of N bytes therefore issues N+1 requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low transaction select |
| sio_in | input | 4 | Data lines as seen from the pads |
| sio_out | output | 4 | Data driven toward the pads |
| sio_oe | output | 4 | Per-line output enable |
| cmd_valid | output | 1 | One-cycle strobe: command and address decoded |
| cmd_opcode | output | 8 | Opcode of the current command |
| cmd_addr | output | 8*ADDR_BYTES (24) | Address of the current command |
| wr_valid | output | 1 | One-cycle strobe per written data byte |
| wr_data | output | 8 | Written data byte |
| rd_req | output | 1 | One-cycle request for the next byte to send |
| rd_data | input | 8 | Byte to send, supplied by the back end |

## Verification
The bench targets mode switching in both directions. A design that switched too early or left the width unchanged would show up as misaligned nibbles, or as bits on the wrong line in the next read. It also sends rejected opcodes in single-bit mode and aborts mid-address. A decoder that leaked there would raise a command or write strobe, or turn the output drivers on. Dummy-byte length is checked in both widths, because a wrong count shifts every returned byte. Each read also counts the fetch requests, since a missing prefetch would repeat stale data.

// File: rtl/sqf_pkg.sv
package sqf_pkg;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_DOUT,
        PH_DIN,
        PH_SKIP
    } phase_e;

    localparam int UNIT_CNT_W = 3;

    // index of the final transfer unit of a byte for the current width
    function automatic logic [UNIT_CNT_W-1:0] last_unit(input logic quad);
        return quad ? 3'd1 : 3'd7;
    endfunction

    function automatic logic [7:0] shift_in(input logic [7:0] acc, input logic quad,
                                            input logic [3:0] sio);
        return quad ? {acc[3:0], sio} : {acc[6:0], sio[0]};
    endfunction

    function automatic logic [3:0] out_unit(input logic [7:0] sh, input logic quad);
        return quad ? sh[7:4] : {2'b00, sh[7], 1'b0};
    endfunction

    function automatic logic [3:0] oe_mask(input logic quad);
        return quad ? 4'b1111 : 4'b0010;
    endfunction

endpackage

// File: rtl/sqf_edges.sv
module sqf_edges (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck;
    end

    // edges count only while the transaction is selected
    assign sck_rise = !cs_n &&  sck && !sck_q;
    assign sck_fall = !cs_n && !sck &&  sck_q;

endmodule

// File: rtl/sqf_deser.sv
module sqf_deser import sqf_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       rise,
    input  logic       quad,
    input  logic [3:0] sio_in,
    output logic       byte_done,
    output logic [7:0] byte_val
);
    logic [7:0]            acc;
    logic [UNIT_CNT_W-1:0] cnt;

    assign byte_val  = shift_in(acc, quad, sio_in);
    assign byte_done = rise && (cnt == last_unit(quad));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
            cnt <= '0;
        end else if (rise) begin
            acc <= byte_val;
            cnt <= byte_done ? '0 : cnt + 3'd1;
        end
    end

    AST_UNIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_unit(quad)); // R3

endmodule

// File: rtl/sqf_ser.sv
module sqf_ser import sqf_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       quad,
    input  logic       rise,
    input  logic       fall,
    input  logic [7:0] rd_data,
    output logic [3:0] sio_out,
    output logic       byte_req
);
    logic [7:0]            sh;
    logic [7:0]            sh_n;
    logic [UNIT_CNT_W-1:0] cnt;

    always_comb begin
        if (cnt == '0)  sh_n = rd_data;
        else if (quad)  sh_n = {sh[3:0], 4'b0000};
        else            sh_n = {sh[6:0], 1'b0};
    end

    // host has just sampled the final unit of a byte: fetch the next one
    assign byte_req = active && rise && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            sh      <= '0;
            cnt     <= '0;
            sio_out <= '0;
        end else if (fall) begin
            sh      <= sh_n;
            sio_out <= out_unit(sh_n, quad);
            cnt     <= (cnt == last_unit(quad)) ? '0 : cnt + 3'd1;
        end
    end

    AST_REQ_SPACING: assert property (@(posedge clk) disable iff (rst)
        byte_req |=> !byte_req); // R11

endmodule

// File: rtl/sqf_ctrl.sv
module sqf_ctrl import sqf_pkg::*; #(
    parameter int         ADDR_BYTES = 3,
    parameter logic [7:0] OP_READ    = 8'h03,
    parameter logic [7:0] OP_FREAD   = 8'h0B,
    parameter logic [7:0] OP_IDREAD  = 8'h9F,
    parameter logic [7:0] OP_QEN     = 8'h38,
    parameter logic [7:0] OP_QRST    = 8'hFF,
    localparam int        ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              byte_done,
    input  logic [7:0]        byte_val,
    input  logic              byte_req,
    output phase_e            phase,
    output logic              quad,
    output logic              cmd_valid,
    output logic [7:0]        cmd_opcode,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_valid,
    output logic [7:0]        wr_data,
    output logic              rd_req
);
    localparam int ACNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    logic [ACNT_W-1:0] acnt;
    logic              is_read, is_fread, is_id;

    assign is_read  = (byte_val == OP_READ);
    assign is_fread = (byte_val == OP_FREAD);
    assign is_id    = (byte_val == OP_IDREAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_OPC;
            quad       <= 1'b0;
            acnt       <= '0;
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
            cmd_addr   <= '0;
            wr_valid   <= 1'b0;
            wr_data    <= '0;
            rd_req     <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            wr_valid  <= 1'b0;
            rd_req    <= byte_req;
            if (cs_n) begin
                phase <= PH_OPC;
                acnt  <= '0;
            end else if (byte_done) begin
                unique case (phase)
                    PH_OPC: begin
                        cmd_opcode <= byte_val;
                        acnt       <= '0;
                        if (is_read || is_fread) begin
                            phase <= PH_ADDR;
                        end else if (is_id) begin
                            phase     <= PH_DOUT;
                            cmd_addr  <= '0;
                            cmd_valid <= 1'b1;
                            rd_req    <= 1'b1;
                        end else if (byte_val == OP_QEN) begin
                            quad  <= 1'b1;
                            phase <= PH_SKIP;
                        end else if (byte_val == OP_QRST) begin
                            quad  <= 1'b0;
                            phase <= PH_SKIP;
                        end else begin
                            phase <= quad ? PH_ADDR : PH_SKIP;
                        end
                    end
                    PH_ADDR: begin
                        cmd_addr <= (cmd_addr << 8) | ADDR_W'(byte_val);
                        acnt     <= acnt + 1'b1;
                        if (acnt == ACNT_W'(ADDR_BYTES - 1)) begin
                            acnt      <= '0;
                            cmd_valid <= 1'b1;
                            if (cmd_opcode == OP_READ) begin
                                phase  <= PH_DOUT;
                                rd_req <= 1'b1;
                            end else if (cmd_opcode == OP_FREAD) begin
                                phase <= PH_DUMMY;
                            end else begin
                                phase <= PH_DIN;
                            end
                        end
                    end
                    PH_DUMMY: begin
                        phase  <= PH_DOUT;
                        rd_req <= 1'b1;
                    end
                    PH_DIN: begin
                        wr_valid <= 1'b1;
                        wr_data  <= byte_val;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_WR_QUAD_ONLY: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> quad); // R2

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !(cmd_valid || wr_valid || rd_req)); // R5

endmodule

// File: rtl/sqf_front.sv
module sqf_front import sqf_pkg::*; #(
    parameter int         ADDR_BYTES = 3,
    parameter logic [7:0] OP_READ    = 8'h03,
    parameter logic [7:0] OP_FREAD   = 8'h0B,
    parameter logic [7:0] OP_IDREAD  = 8'h9F,
    parameter logic [7:0] OP_QEN     = 8'h38,
    parameter logic [7:0] OP_QRST    = 8'hFF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sck,
    input  logic                    cs_n,
    input  logic [3:0]              sio_in,
    output logic [3:0]              sio_out,
    output logic [3:0]              sio_oe,
    output logic                    cmd_valid,
    output logic [7:0]              cmd_opcode,
    output logic [8*ADDR_BYTES-1:0] cmd_addr,
    output logic                    wr_valid,
    output logic [7:0]              wr_data,
    output logic                    rd_req,
    input  logic [7:0]              rd_data
);
    logic       sck_rise, sck_fall;
    logic       byte_done, byte_req, quad, in_dout;
    logic [7:0] byte_val;
    phase_e     phase;

    sqf_edges u_edges (
        .clk      (clk),
        .rst      (rst),
        .sck      (sck),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    sqf_deser u_deser (
        .clk       (clk),
        .rst       (rst),
        .clear     (cs_n),
        .rise      (sck_rise),
        .quad      (quad),
        .sio_in    (sio_in),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    sqf_ctrl #(
        .ADDR_BYTES (ADDR_BYTES),
        .OP_READ    (OP_READ),
        .OP_FREAD   (OP_FREAD),
        .OP_IDREAD  (OP_IDREAD),
        .OP_QEN     (OP_QEN),
        .OP_QRST    (OP_QRST)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .byte_done  (byte_done),
        .byte_val   (byte_val),
        .byte_req   (byte_req),
        .phase      (phase),
        .quad       (quad),
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .cmd_addr   (cmd_addr),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .rd_req     (rd_req)
    );

    assign in_dout = (phase == PH_DOUT);

    sqf_ser u_ser (
        .clk      (clk),
        .rst      (rst),
        .active   (in_dout),
        .quad     (quad),
        .rise     (sck_rise),
        .fall     (sck_fall),
        .rd_data  (rd_data),
        .sio_out  (sio_out),
        .byte_req (byte_req)
    );

    assign sio_oe = in_dout ? oe_mask(quad) : 4'b0000;

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (sio_oe == 4'b0000)); // R10

    AST_OE_START_FETCH: assert property (@(posedge clk) disable iff (rst)
        $rose(sio_oe != 4'b0000) |-> rd_req); // R11

endmodule

// File: tb/sqf_front_bench.sv
module sqf_front_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  sio_in = 4'h0;
    logic [3:0]  sio_out, sio_oe;
    logic        cmd_valid, wr_valid, rd_req;
    logic [7:0]  cmd_opcode, wr_data;
    logic [23:0] cmd_addr;
    logic [7:0]  rd_data = 8'h00;

    always #10 clk = ~clk;

    sqf_front u_sqf_front (
        .clk (clk), .rst (rst), .sck (sck), .cs_n (cs_n), .sio_in (sio_in),
        .sio_out (sio_out), .sio_oe (sio_oe), .cmd_valid (cmd_valid),
        .cmd_opcode (cmd_opcode), .cmd_addr (cmd_addr), .wr_valid (wr_valid),
        .wr_data (wr_data), .rd_req (rd_req), .rd_data (rd_data)
    );

    int          total = 0, bad = 0;
    int          n_cmd = 0, n_wr = 0, n_req = 0, idx = 0;
    bit          done = 1'b0;
    bit          m_quad = 1'b0;
    logic [3:0]  exp_oe = 4'h0;
    logic [7:0]  cur_op = 8'h00;
    logic [23:0] cur_addr = 24'h0;
    logic [7:0]  q_op[$];
    logic [23:0] q_addr[$];
    logic [7:0]  q_wr[$];

    function automatic logic [7:0] mem_byte(logic [7:0] op, logic [23:0] a, int i);
        logic [23:0] x;
        if (op == 8'h9F) begin
            case (i % 3)
                0:       return 8'hBF;
                1:       return 8'h26;
                default: return 8'h42;
            endcase
        end
        x = a + 24'(i);
        return x[7:0] ^ x[15:8] ^ 8'hC3;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference back end and per-clock comparison
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            check(sio_oe == exp_oe, "R10", "sio_oe", 32'(sio_oe), 32'(exp_oe));
            if (cmd_valid) begin
                n_cmd++;
                if (q_op.size() == 0) begin
                    check(1'b0, "R2", "unexpected cmd_valid", 32'(cmd_opcode), 32'h0);
                end else begin
                    logic [7:0]  eo;
                    logic [23:0] ea;
                    eo = q_op.pop_front();
                    ea = q_addr.pop_front();
                    check(cmd_opcode == eo, "R1", "cmd_opcode", 32'(cmd_opcode), 32'(eo));
                    check(cmd_addr == ea, "R1", "cmd_addr", 32'(cmd_addr), 32'(ea));
                end
                cur_op   = cmd_opcode;
                cur_addr = cmd_addr;
                idx      = 0;
            end
            if (wr_valid) begin
                n_wr++;
                if (q_wr.size() == 0) begin
                    check(1'b0, "R8", "unexpected wr_valid", 32'(wr_data), 32'h0);
                end else begin
                    logic [7:0] ew;
                    ew = q_wr.pop_front();
                    check(wr_data == ew, "R8", "wr_data", 32'(wr_data), 32'(ew));
                end
            end
            if (rd_req) begin
                n_req++;
                rd_data = mem_byte(cur_op, cur_addr, idx);
                idx++;
            end
        end
    end

    task automatic unit(input logic [3:0] v, output logic [3:0] cap);
        @(negedge clk); sck = 1'b0; sio_in = v;
        @(negedge clk);
        @(negedge clk); cap = sio_out; sck = 1'b1;
        @(posedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [3:0] c;
        if (m_quad) begin
            unit(b[7:4], c);
            unit(b[3:0], c);
        end else begin
            for (int i = 7; i >= 0; i--) unit({3'b000, b[i]}, c);
        end
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic [3:0] c;
        if (m_quad) begin
            unit(4'h0, c); b[7:4] = c;
            unit(4'h0, c); b[3:0] = c;
        end else begin
            for (int i = 7; i >= 0; i--) begin
                unit(4'h0, c);
                b[i] = c[1];
            end
        end
    endtask

    task automatic begin_txn(input bit m3);
        @(negedge clk); sck = m3;
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_txn(input bit m3);
        @(negedge clk); sck = m3;
        @(negedge clk); cs_n = 1'b1;
        @(posedge clk); exp_oe = 4'h0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_txn(input logic [7:0] op, input logic [23:0] a, input int n,
                            input bit m3, input string req);
        logic [7:0] b;
        int c0, r0;
        c0 = n_cmd;
        r0 = n_req;
        begin_txn(m3);
        if (op == 8'h9F) begin
            q_op.push_back(op); q_addr.push_back(24'h0);
            send_byte(op);
        end else begin
            send_byte(op);
            q_op.push_back(op); q_addr.push_back(a);
            send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
            if (op == 8'h0B) send_byte(8'h00);
        end
        exp_oe = m_quad ? 4'b1111 : 4'b0010;
        for (int i = 0; i < n; i++) begin
            recv_byte(b);
            check(b == mem_byte(op, (op == 8'h9F) ? 24'h0 : a, i), req, "read byte",
                  32'(b), 32'(mem_byte(op, (op == 8'h9F) ? 24'h0 : a, i)));
        end
        end_txn(m3);
        check(n_cmd == c0 + 1, req, "command count", 32'(n_cmd), 32'(c0 + 1));
        check(n_req == r0 + n + 1, "R11", "fetch count", 32'(n_req), 32'(r0 + n + 1));
    endtask

    task automatic write_txn(input logic [7:0] op, input logic [23:0] a, input int n,
                             input bit m3);
        int w0;
        w0 = n_wr;
        begin_txn(m3);
        send_byte(op);
        q_op.push_back(op); q_addr.push_back(a);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
        for (int i = 0; i < n; i++) begin
            q_wr.push_back(8'h5A + 8'(i * 17));
            send_byte(8'h5A + 8'(i * 17));
        end
        end_txn(m3);
        check(n_wr == w0 + n, "R8", "write strobes", 32'(n_wr), 32'(w0 + n));
    endtask

    task automatic quiet_txn(input logic [7:0] op, input int extra, input bit m3,
                             input string req);
        int c0, w0, r0;
        c0 = n_cmd; w0 = n_wr; r0 = n_req;
        begin_txn(m3);
        send_byte(op);
        for (int i = 0; i < extra; i++) send_byte(8'hA5 ^ 8'(i));
        end_txn(m3);
        check(n_cmd == c0 && n_wr == w0 && n_req == r0, req, "events from ignored opcode",
              32'(n_cmd + n_wr + n_req), 32'(c0 + w0 + r0));
    endtask

    task automatic abort_txn(input bit m3);
        logic [3:0] c;
        int c0;
        c0 = n_cmd;
        begin_txn(m3);
        send_byte(8'h03);
        send_byte(8'h12);
        send_byte(8'h34);
        unit(4'h1, c);
        end_txn(m3);
        check(n_cmd == c0, "R5", "cmd after abort", 32'(n_cmd), 32'(c0));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sio_oe == 4'h0, "R1", "reset sio_oe", 32'(sio_oe), 32'h0);
        check(!cmd_valid && !wr_valid && !rd_req, "R1", "reset strobes",
              32'({cmd_valid, wr_valid, rd_req}), 32'h0);

        read_txn(8'h03, 24'h012345, 4, 1'b0, "R1");
        read_txn(8'h03, 24'h00FFFE, 3, 1'b1, "R4");
        read_txn(8'h0B, 24'h1000F0, 3, 1'b0, "R6");
        read_txn(8'h9F, 24'h0, 3, 1'b1, "R7");
        quiet_txn(8'h32, 4, 1'b0, "R2");
        quiet_txn(8'h02, 2, 1'b1, "R2");
        abort_txn(1'b0);
        read_txn(8'h03, 24'h0000AA, 2, 1'b0, "R5");
        quiet_txn(8'hFF, 0, 1'b0, "R9");
        read_txn(8'h03, 24'h00BEEF, 2, 1'b1, "R9");

        quiet_txn(8'h38, 0, 1'b0, "R3");
        m_quad = 1'b1;
        read_txn(8'h03, 24'hABCDEF, 4, 1'b0, "R3");
        read_txn(8'h03, 24'h7FFFFF, 3, 1'b1, "R4");
        read_txn(8'h0B, 24'h000100, 3, 1'b0, "R6");
        read_txn(8'h9F, 24'h0, 4, 1'b0, "R7");
        write_txn(8'h32, 24'h345678, 3, 1'b1);
        write_txn(8'h02, 24'h000001, 1, 1'b0);
        abort_txn(1'b1);
        read_txn(8'h03, 24'h222222, 2, 1'b1, "R5");

        quiet_txn(8'hFF, 0, 1'b0, "R9");
        m_quad = 1'b0;
        read_txn(8'h03, 24'h123456, 3, 1'b0, "R9");
        quiet_txn(8'h32, 3, 1'b0, "R2");
        check(q_op.size() == 0 && q_wr.size() == 0, "R8", "pending expected events",
              32'(q_op.size() + q_wr.size()), 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule